// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recently used translations from virtual page number to physical frame number. A translation lookup presents a 20-bit page number and receives, in the same cycle, a hit flag and the matching 20-bit frame number. A hit means the request can skip the page walk. After a walk completes, the walker writes the new translation through the fill port. When the page-directory base changes, the owner of the block raises flush, which drops every cached translation.

There are four slots, and all of them are compared against the lookup key in parallel. A new translation goes into the slot chosen by a rotating victim pointer. If the page number is already cached, the fill instead refreshes that slot in place. Each cycle a small action decoder settles on one of four named actions:

- IDLE: no fill and no flush.
- INSERT: a fill of a new page into the victim slot, after which the pointer moves on.
- UPDATE: a fill of a page that is already cached. The existing slot is rewritten and the pointer stays where it is.
- FLUSH: all slots are invalidated and the pointer returns to slot 0.

The only transitions are those of the victim pointer. INSERT moves it from slot k to slot k+1, and from slot 3 back to slot 0. FLUSH and reset move it to slot 0. IDLE and UPDATE leave it unchanged.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses, and the victim pointer selects slot 0.
- R2: A lookup hits when a valid slot holds a page number equal to `lk_vpn`. `lk_hit` is then 1 and `lk_pfn` carries that slot's frame number in the same cycle, with no clock edge in between.
- R3: On a miss, `lk_hit` is 0 and `lk_pfn` is 0.
- R4: A fill of a page number that is not cached writes page and frame into the slot under the victim pointer and marks it valid, on the next rising edge. The pointer then advances by one.
- R5: The victim pointer wraps from slot 3 to slot 0. The fifth distinct fill after reset therefore evicts the translation written by the first.
- R6: A fill whose page number is already cached rewrites that slot's frame number and leaves the pointer unchanged. A page number is never held in two slots.
- R7: Flush invalidates every slot on the next edge and returns the pointer to slot 0.
- R8: When fill and flush are both high in the same cycle, the flush takes effect and the fill is discarded.
- R9: A fill is not visible to a lookup in the cycle in which it is presented. It becomes visible only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup found a valid matching slot |
| lk_pfn | output | 20 | Frame number of the hit, 0 on a miss |
| fill_en | input | 1 | Write a completed translation |
| fill_vpn | input | 20 | Page number to store |
| fill_pfn | input | 20 | Frame number to store |
| flush | input | 1 | Invalidate all slots and reset the pointer |

## Verification
The bench fills the cache past its capacity several times, cycling through a pool of six page numbers. After every step it probes all six pages and compares the results with a model built from the requirements. This catches a pointer that fails to wrap: that design would evict the wrong slot on the fifth insert. It also catches a design that advances the pointer on a refresh, which would evict a live translation too early, or one that stores a duplicate, which would leave two slots answering the same page. The bench also raises flush together with a fill and checks that nothing survives; a design that let the fill win would hit afterwards. Finally it probes a page while its fill is still pending, which exposes a write path that bypasses the clock edge.

// File: rtl/xc_pkg.sv
package xc_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_INSERT,
        ACT_UPDATE,
        ACT_FLUSH
    } xc_act_e;
endpackage

// File: rtl/xc_tag_match.sv
module xc_tag_match #(
    parameter int SLOTS = 4,
    parameter int KEY_W = 20
) (
    input  logic [KEY_W-1:0]            key,
    input  logic [SLOTS-1:0]            valid,
    input  logic [SLOTS-1:0][KEY_W-1:0] tags,
    output logic [SLOTS-1:0]            hit_vec
);
    // one comparator per slot, all evaluated in parallel
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/xc_victim_ptr.sv
module xc_victim_ptr #(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xc_entry_store.sv
module xc_entry_store #(
    parameter int SLOTS = 4,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [VPN_W-1:0]            wr_vpn,
    input  logic [PFN_W-1:0]            wr_pfn,
    output logic [SLOTS-1:0]            valid,
    output logic [SLOTS-1:0][VPN_W-1:0] vpns,
    output logic [SLOTS-1:0][PFN_W-1:0] pfns
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    // payload needs no reset: it is only observed through a valid slot
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            vpns[wr_idx] <= wr_vpn;
            pfns[wr_idx] <= wr_pfn;
        end
    end

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid == '0));

    p_write_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> valid[$past(wr_idx)]);

    p_write_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (pfns[$past(wr_idx)] == $past(wr_pfn)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int SLOTS = 4,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush
);
    import xc_pkg::*;

    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    logic [SLOTS-1:0]            valid;
    logic [SLOTS-1:0][VPN_W-1:0] vpns;
    logic [SLOTS-1:0][PFN_W-1:0] pfns;
    logic [SLOTS-1:0]            lk_vec;
    logic [SLOTS-1:0]            fl_vec;
    logic [IDX_W-1:0]            victim;
    logic [IDX_W-1:0]            fl_idx;
    logic [IDX_W-1:0]            wr_idx;
    logic                        wr_en;
    xc_act_e                     act;

    xc_tag_match #(.SLOTS(SLOTS), .KEY_W(VPN_W)) u_lk_match (
        .key     (lk_vpn),
        .valid   (valid),
        .tags    (vpns),
        .hit_vec (lk_vec)
    );

    xc_tag_match #(.SLOTS(SLOTS), .KEY_W(VPN_W)) u_fl_match (
        .key     (fill_vpn),
        .valid   (valid),
        .tags    (vpns),
        .hit_vec (fl_vec)
    );

    // action decode: flush dominates any fill
    always_comb begin
        if (flush)
            act = ACT_FLUSH;
        else if (fill_en && (|fl_vec))
            act = ACT_UPDATE;
        else if (fill_en)
            act = ACT_INSERT;
        else
            act = ACT_IDLE;
    end

    always_comb begin
        fl_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (fl_vec[i]) fl_idx = IDX_W'(i);
        end
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = victim;
        unique case (act)
            ACT_INSERT: begin
                wr_en  = 1'b1;
                wr_idx = victim;
            end
            ACT_UPDATE: begin
                wr_en  = 1'b1;
                wr_idx = fl_idx;
            end
            ACT_FLUSH,
            ACT_IDLE: begin
                wr_en  = 1'b0;
                wr_idx = victim;
            end
            default: begin
                wr_en  = 1'b0;
                wr_idx = victim;
            end
        endcase
    end

    xc_victim_ptr #(.SLOTS(SLOTS)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (act == ACT_INSERT),
        .clr   (act == ACT_FLUSH),
        .ptr   (victim)
    );

    xc_entry_store #(.SLOTS(SLOTS), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (act == ACT_FLUSH),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_vpn (fill_vpn),
        .wr_pfn (fill_pfn),
        .valid  (valid),
        .vpns   (vpns),
        .pfns   (pfns)
    );

    // output mux: at most one slot matches, so an OR of masked frames is exact
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (lk_vec[i]) lk_pfn = lk_pfn | pfns[i];
        end
    end
    assign lk_hit = |lk_vec;

    p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == '0));

    p_insert_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_INSERT) |=>
            (victim == (($past(victim) == LAST) ? '0 : IDX_W'($past(victim) + 1'b1))));

    p_update_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_UPDATE) |=> $stable(victim));

    p_flush_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((victim == '0) && !lk_hit));
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // requirement-level model
    bit        m_v   [4];
    bit [19:0] m_vpn [4];
    bit [19:0] m_pfn [4];
    int        m_ptr;

    always #2.5 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .lk_hit   (lk_hit),
        .lk_pfn   (lk_pfn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_pfn (fill_pfn),
        .flush    (flush)
    );

    function automatic bit [19:0] pool_vpn(int k);
        return 20'h00A00 + 20'(k * 20'h01011);
    endfunction

    task automatic probe(input bit [19:0] v, input string tag);
        bit        eh = 1'b0;
        bit [19:0] ep = '0;
        for (int i = 0; i < 4; i++)
            if (m_v[i] && m_vpn[i] == v) begin eh = 1'b1; ep = m_pfn[i]; end
        lk_vpn = v;
        #0.5;
        checks++;
        if (lk_hit !== eh || lk_pfn !== ep) begin
            fails++;
            $display("FAIL %s vpn=%h actual hit=%b pfn=%h expected hit=%b pfn=%h",
                     tag, v, lk_hit, lk_pfn, eh, ep);
        end
    endtask

    task automatic model_fill(input bit [19:0] v, input bit [19:0] p);
        int hit_i = -1;
        for (int i = 0; i < 4; i++)
            if (m_v[i] && m_vpn[i] == v) hit_i = i;
        if (hit_i >= 0) begin
            m_pfn[hit_i] = p;
        end else begin
            m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = v; m_pfn[m_ptr] = p;
            m_ptr = (m_ptr + 1) % 4;
        end
    endtask

    task automatic model_flush();
        for (int i = 0; i < 4; i++) m_v[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic do_fill(input bit [19:0] v, input bit [19:0] p, input bit fl);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = v; fill_pfn = p; flush = fl;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
        if (fl) model_flush(); else model_fill(v, p);
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 6; k++) probe(pool_vpn(k), tag);
    endtask

    initial begin
        model_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        sweep("R1");
        probe(20'h00000, "R1");
        probe(20'hFFFFF, "R3");

        // R2/R4: fill four, each visible with its frame
        for (int k = 0; k < 4; k++) begin
            do_fill(pool_vpn(k), 20'h10000 + 20'(k), 1'b0);
            sweep("R4");
        end
        probe(pool_vpn(2), "R2");

        // R5: fifth distinct page evicts slot 0 (first fill)
        do_fill(pool_vpn(4), 20'h20004, 1'b0);
        sweep("R5");

        // R6: refresh existing page, pointer must not move
        do_fill(pool_vpn(2), 20'h3ABCD, 1'b0);
        sweep("R6");
        do_fill(pool_vpn(5), 20'h20005, 1'b0); // should evict pool 1 (slot 1)
        sweep("R6");

        // R9: pending fill invisible before the edge
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = pool_vpn(0); fill_pfn = 20'h55555;
        probe(pool_vpn(0), "R9");
        @(negedge clk);
        fill_en = 1'b0;
        model_fill(pool_vpn(0), 20'h55555);
        probe(pool_vpn(0), "R9");

        // near-exhaustive sequence over the pool, mixing inserts and refreshes
        for (int n = 0; n < 60; n++) begin
            do_fill(pool_vpn((n * 5 + n / 7) % 6), 20'(n * 20'h00313 + 1), 1'b0);
            sweep("R5");
        end

        // R7: flush empties and resets pointer
        do_fill('0, '0, 1'b1);
        sweep("R7");
        do_fill(pool_vpn(3), 20'h0C0DE, 1'b0);
        for (int k = 0; k < 4; k++) do_fill(pool_vpn(k == 3 ? 5 : k), 20'h0E000 + 20'(k), 1'b0);
        sweep("R7");

        // R8: flush with a simultaneous fill
        do_fill(pool_vpn(4), 20'h0BEEF, 1'b1);
        sweep("R8");
        for (int k = 0; k < 5; k++) begin
            do_fill(pool_vpn(k), 20'h0F000 + 20'(k), 1'b0);
            sweep("R5");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule